// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is a bus master for a narrow external bus on which the low address byte and the data byte share the same lines. A core-side client hands it one transfer at a time: an address, a write byte, a read/write flag and a memory/port flag. The sequencer then steps through a fixed set of bus phases and returns a single-cycle completion pulse, together with the byte it read.

Each transfer starts with an address phase. In this phase the whole address is placed on the pins and a latch strobe is pulsed, so that external logic can hold the low byte. In the following phases the shared lines either carry the write byte or are released so that the target can drive them. Active-low read and write strobes frame the access, and an active-low buffer enable is asserted for the same window. A slow target holds the ready input low, and each low sample adds one wait phase before the read data is captured. The write byte stays on the shared lines through the final phase, which gives hold time after the write strobe rises.

A new request may arrive in the final phase of the current transfer, and the next transfer then starts without an idle gap.

Top module: `bus_cycle_seq`

## Requirements
- R1: A transfer with ready high on every sample occupies exactly four clocks in the order T1, T2, T3, T4. `req_ready` is 1 only while idle or in T4.
- R2: In T1, `bus_addr_hi` carries the upper address bits, `ad_out` carries address bits [DATA_W-1:0] with `ad_oe`=1, and `ale`=1. `ale` is 0 in every other phase and while idle.
- R3: `io_m` is 0 for a memory transfer (`req_io`=0) and 1 for a port transfer (`req_io`=1). It holds that value from T1 through T4 and is 0 while idle. `bus_addr_hi` holds the upper address bits from T1 through T4.
- R4: `rd_n`, `wr_n` and `den_n` are active low and are 1 while idle and in T1 and T4. From T2 through T3, including wait phases, `den_n`=0 and only the strobe that matches the direction is 0: `rd_n` for a read (`req_write`=0), `wr_n` for a write (`req_write`=1).
- R5: `ready_in` is sampled at the clock edge that ends T2 and at the edge that ends each wait phase. A 0 sample makes the next phase a wait phase (TW), and a 1 sample makes it T3. N consecutive 0 samples therefore give exactly N wait phases. During a wait phase the strobes and shared lines keep their T2 values.
- R6: For a read, `ad_in` is captured into `rd_data` at the clock edge that ends T3. `rd_data` shows that byte from T4 on and keeps it until the next read capture. Write transfers leave it unchanged.
- R7: `dt_r` is 1 for the whole of a write transfer (T1 through T4) and 0 for the whole of a read transfer and while idle.
- R8: For a write, `ad_out` equals the write byte with `ad_oe`=1 from T2 through T4, so the byte is still driven in the clock after `wr_n` returns to 1.
- R9: For a read, `ad_oe` is 0 from T2 through T4. `ad_oe` is 0 whenever no transfer is active.
- R10: `done` is 1 for exactly the T4 clock of each transfer. A request present in T4 starts T1 on the next clock, with no idle clock between the two transfers.
- R11: A request raised during T1, T2, wait phases or T3 and withdrawn before T4 is ignored: the address pins keep the current transfer and the sequencer returns to idle after T4.
- R12: While reset is asserted and right after it is released, the block is idle: no strobe is active, `ale`=0, `ad_oe`=0, `done`=0, `rd_data`=0, and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request from the core |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Byte to write |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = port space, 0 = memory space |
| req_ready | output | 1 | Request is taken this clock if valid |
| done | output | 1 | One-clock completion pulse (T4) |
| rd_data | output | DATA_W | Last byte read |
| bus_addr_hi | output | ADDR_W-DATA_W | Upper address pins |
| ad_out | output | DATA_W | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | DATA_W | Shared address/data lines, incoming value |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Buffer direction, 1 = transmit |
| io_m | output | 1 | 1 = port access, 0 = memory access |
| ready_in | input | 1 | Target ready, sampled at end of T2 and each wait |

## Verification
The bench builds the block with its defaults: a 20-bit address and a byte-wide shared bus, so 12 upper address pins. With these values the full address split, the low-byte multiplexing and the captured read byte can be checked bit for bit with distinct patterns in each field. The bench runs reads and writes in both address spaces with 0, 1 and 3 wait phases. It also runs a back-to-back pair started from T4, and a request raised and withdrawn mid-transfer. Every pin is compared with a phase-by-phase expectation on each clock.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  // Next bus phase from the present one, the sampled ready and a taken request.
  function automatic phase_e phase_step(phase_e cur, logic rdy, logic start);
    phase_e nxt;
    case (cur)
      PH_IDLE:      nxt = start ? PH_T1 : PH_IDLE;
      PH_T1:        nxt = PH_T2;
      PH_T2, PH_TW: nxt = rdy ? PH_T3 : PH_TW;
      PH_T3:        nxt = PH_T4;
      PH_T4:        nxt = start ? PH_T1 : PH_IDLE;
      default:      nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // Phases in which a new request may be taken.
  function automatic logic phase_accepts(phase_e p);
    return (p == PH_IDLE) || (p == PH_T4);
  endfunction

  // Phases in which strobes and the data buffer are active.
  function automatic logic phase_strobed(phase_e p);
    return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
  endfunction

  // Phases in which ready is sampled at the closing edge.
  function automatic logic phase_samples_ready(phase_e p);
    return (p == PH_T2) || (p == PH_TW);
  endfunction

  // Any phase belonging to a transfer.
  function automatic logic phase_busy(phase_e p);
    return p != PH_IDLE;
  endfunction

endpackage

// File: rtl/bseq_phase_fsm.sv
module bseq_phase_fsm
  import busseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ready_in,
  output phase_e phase
);

  phase_e phase_nxt;

  always_comb phase_nxt = phase_step(phase, ready_in, start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  logic in_t1, in_t3, wait_sample_lo, wait_sample_hi;
  assign in_t1          = (phase == PH_T1);
  assign in_t3          = (phase == PH_T3);
  assign wait_sample_lo = phase_samples_ready(phase) && !ready_in;
  assign wait_sample_hi = phase_samples_ready(phase) && ready_in;

  assert_t1_then_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_t1 |=> (phase == PH_T2));
  assert_t3_then_t4_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_t3 |=> (phase == PH_T4));
  assert_wait_inserted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_sample_lo |=> (phase == PH_TW));
  assert_wait_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_sample_hi |=> (phase == PH_T3));

endmodule

// File: rtl/bseq_req_latch.sv
module bseq_req_latch #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_write,
  input  logic              in_io,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              cur_write,
  output logic              cur_io
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      cur_io    <= 1'b0;
    end else if (take) begin
      cur_addr  <= in_addr;
      cur_wdata <= in_wdata;
      cur_write <= in_write;
      cur_io    <= in_io;
    end
  end

  assert_hold_without_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cur_addr) && $stable(cur_write) && $stable(cur_io));

endmodule

// File: rtl/bseq_pin_drive.sv
module bseq_pin_drive
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic              cur_write,
  input  logic              cur_io,
  output logic [HI_W-1:0]   bus_addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dt_r,
  output logic              io_m
);

  logic busy, strobed, addr_phase;
  assign busy       = phase_busy(phase);
  assign strobed    = phase_strobed(phase);
  assign addr_phase = (phase == PH_T1);

  always_comb begin
    bus_addr_hi = busy ? cur_addr[ADDR_W-1:DATA_W] : '0;
    io_m        = busy & cur_io;
    dt_r        = busy & cur_write;
    ale         = addr_phase;
    rd_n        = !(strobed && !cur_write);
    wr_n        = !(strobed && cur_write);
    den_n       = !strobed;
    if (addr_phase) begin
      ad_out = cur_addr[DATA_W-1:0];
      ad_oe  = 1'b1;
    end else if (busy && cur_write) begin
      ad_out = cur_wdata;
      ad_oe  = 1'b1;
    end else begin
      ad_out = '0;
      ad_oe  = 1'b0;
    end
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_strobe_needs_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !den_n);
  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe));
  assert_read_releases_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

endmodule

// File: rtl/bseq_rd_capture.sv
module bseq_rd_capture
  import busseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              cur_write,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rd_data
);

  logic cap_en;
  assign cap_en = (phase == PH_T3) && !cur_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (cap_en) rd_data <= ad_in;
  end

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rd_data));
  assert_rd_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (rd_data == $past(ad_in)));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_write,
  input  logic                     req_io,
  output logic                     req_ready,
  output logic                     done,
  output logic [DATA_W-1:0]        rd_data,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     dt_r,
  output logic                     io_m,
  input  logic                     ready_in
);

  phase_e            phase;
  logic              start;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write, cur_io;

  assign req_ready = phase_accepts(phase);
  assign start     = req_valid && req_ready;
  assign done      = (phase == PH_T4);

  bseq_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ready_in(ready_in), .phase(phase)
  );

  bseq_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .take(start),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_write(req_write), .in_io(req_io),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_write(cur_write), .cur_io(cur_io)
  );

  bseq_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_write(cur_write), .cur_io(cur_io),
    .bus_addr_hi(bus_addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .io_m(io_m)
  );

  bseq_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cur_write(cur_write),
    .ad_in(ad_in), .rd_data(rd_data)
  );

  logic mid_cycle;
  assign mid_cycle = phase_busy(phase) && (phase != PH_T1);

  assert_ale_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_dir_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mid_cycle |-> $stable(dt_r));
  assert_space_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mid_cycle |-> $stable(io_m) && $stable(bus_addr_hi));
  assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !den_n) |-> !req_ready);

endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int HW = AW - DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_io = 0, ready_in = 1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ad_in = '0;
  logic          req_ready, done, ad_oe, ale, rd_n, wr_n, den_n, dt_r, io_m;
  logic [DW-1:0] rd_data, ad_out;
  logic [HW-1:0] bus_addr_hi;

  bus_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .bus_addr_hi(bus_addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
    .io_m(io_m), .ready_in(ready_in)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state for the transfer in flight
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_last_rd;
  logic          m_write, m_io;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ph: 0 idle, 1 T1, 2 T2, 3 TW, 4 T3, 5 T4
  task automatic model_cmp(int ph);
    bit busy = (ph != 0);
    bit strb = (ph == 2 || ph == 3 || ph == 4);
    chk("R2", "ale", ale, ph == 1);
    chk("R4", "rd_n", rd_n, !(strb && !m_write));
    chk("R4", "wr_n", wr_n, !(strb && m_write));
    chk("R4", "den_n", den_n, !strb);
    chk("R7", "dt_r", dt_r, busy && m_write);
    chk("R3", "io_m", io_m, busy && m_io);
    chk("R3", "addr_hi", bus_addr_hi, busy ? m_addr[AW-1:DW] : 0);
    chk("R10", "done", done, ph == 5);
    chk("R1", "req_ready", req_ready, ph == 0 || ph == 5);
    chk("R6", "rd_data", rd_data, m_last_rd);
    if (ph == 1) begin
      chk("R2", "ad_oe", ad_oe, 1);
      chk("R2", "ad_out", ad_out, m_addr[DW-1:0]);
    end else if (busy && m_write) begin
      chk("R8", "ad_oe", ad_oe, 1);
      chk("R8", "ad_out", ad_out, m_wdata);
    end else begin
      chk("R9", "ad_oe", ad_oe, 0);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Called at a negedge with the DUT idle or in T4; returns at the negedge in T4.
  task automatic xfer(bit wr, bit io, logic [AW-1:0] a, logic [DW-1:0] wd,
                      int waits, logic [DW-1:0] rv, bit poke);
    req_valid = 1; req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
    step();
    m_addr = a; m_wdata = wd; m_write = wr; m_io = io;
    req_valid = 0; req_addr = ~a; req_wdata = ~wd;
    model_cmp(1);                                      // R1 T1
    step();
    model_cmp(2);                                      // R1 T2
    ready_in = (waits == 0);
    if (poke) begin
      req_valid = 1; req_addr = 20'h0F0F0; req_write = ~wr; // R11 stray request
    end
    for (int k = 1; k <= waits; k++) begin
      step();
      if (poke) req_valid = 0;
      model_cmp(3);                                    // R5 wait phase
      ready_in = (k == waits);
    end
    step();
    if (poke) req_valid = 0;
    model_cmp(4);                                      // R1 T3
    ad_in = rv;
    ready_in = 0;                                      // not sampled in T3
    step();
    if (!wr) m_last_rd = rv;
    ad_in = ~rv;
    ready_in = 1;
    model_cmp(5);                                      // R10 T4
    if (wr) chk("R8", "wr_n released with data held", {31'd0, wr_n}, 1);
  endtask

  task automatic idle_one();
    step();
    model_cmp(0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_addr = '0; m_wdata = '0; m_write = 0; m_io = 0; m_last_rd = '0;
    @(negedge clk);
    model_cmp(0);                                      // R12 in reset
    step();
    rst_n = 1;
    @(negedge clk);
    model_cmp(0);                                      // R12 after release
    // R1 zero-wait memory read
    xfer(0, 0, 20'h12345, 8'h00, 0, 8'hA5, 0);
    idle_one();                                        // R6 held after T4
    // R5 one wait, port write
    xfer(1, 1, 20'hABCDE, 8'h3C, 1, 8'h00, 0);
    // R10 back-to-back: port read with three waits started from T4
    xfer(0, 1, 20'h5A0F1, 8'h00, 3, 8'h5A, 0);
    // R8 memory write with three waits, back-to-back again
    xfer(1, 0, 20'hFEDCB, 8'hC3, 3, 8'h00, 0);
    idle_one();
    // R11 stray request during a read with one wait
    xfer(0, 0, 20'h80001, 8'h00, 1, 8'h96, 1);
    idle_one();                                        // R11 no extra transfer
    idle_one();
    // R5 write with no waits, then read with one wait
    xfer(1, 1, 20'h00F00, 8'hFF, 0, 8'h00, 0);
    xfer(0, 0, 20'hFFFFF, 8'h00, 1, 8'h01, 0);
    idle_one();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule